// File: doc/BRIEF.md
# Vector Index Sequence Generator

This block builds a 128-bit packed vector whose lanes hold an arithmetic progression of offsets. The offsets feed per-lane addressing for non-contiguous memory access, such as gather loads and scatter stores. A request carries four things:

- a 32-bit scalar start value;
- a step of 1, 2, 4 or 8;
- a direction, either counting up or counting down;
- an element size of 8, 16 or 32 bits.

The element size sets the lane count: 128 divided by the element width. Lane 0 takes the start value. Every later lane differs from the lane below it by the step. Each lane is cut down to its element width.

With the vector the block also returns an updated scalar that points one step past the last lane. Feeding that scalar back as the next start continues the sequence without a gap.

Requests enter through a valid/ready handshake and results leave through another. The result register is a single stage. A new request is taken whenever that stage is empty or is being drained in the same cycle. While the consumer holds ready low, the result stays frozen and no new request is taken. `in_valid` may stay high while `in_ready` is low, and the request waits.

Top module: `vidx_seq_gen`

## Requirements
- R1: Lane 0 of the vector equals the start value truncated to the element width.
- R2: With `in_dec`=0, each lane i>0 equals lane i-1 plus the step, modulo 2^element width.
- R3: With `in_dec`=1, each lane i>0 equals lane i-1 minus the step, modulo 2^element width.
- R4: `in_step` code 0, 1, 2 or 3 selects a step of 1, 2, 4 or 8 respectively.
- R5: `in_esize` code 0 selects 8-bit lanes (16 lanes), code 1 selects 16-bit lanes (8 lanes), and code 2 selects 32-bit lanes (4 lanes). Code 3 behaves as code 2. Lane k occupies bits [k*W +: W], where W is the element width.
- R6: `out_next` equals the start plus the step times the lane count when counting up, or minus that product when counting down, modulo 2^32.
- R7: Lane values wrap at the element width, both above the top of the range and below zero.
- R8: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high with that request's result from the following cycle.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. In that state `out_vec` and `out_next` hold their values, and a pending request does not change them.
- R10: After reset `out_valid` is low, `out_vec` and `out_next` are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_start | input | 32 | Start value for lane 0 |
| in_step | input | 2 | Step code (1, 2, 4, 8) |
| in_dec | input | 1 | 1 counts down, 0 counts up |
| in_esize | input | 2 | Element size code (8, 16, 32 bits) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Packed offset vector |
| out_next | output | 32 | Scalar that continues the sequence |

## Verification
The main function is tried with three patterns, and each separates a different class of fault:
- A 16-bit count-down from 20 by 2 shows whether direction and lane packing are right.
- Count-ups near the top of the 8-bit range, and count-downs near zero, show whether the wrap happens at the element width rather than at 32 bits.
- Each step code and each element-size code, including the reserved size code, is tried. This exposes a mis-decoded step, a wrong lane count in the continuation scalar, and a wrong fallback for the reserved code.

Two further patterns cover the sequence and the handshake:
- Chaining `out_next` into the next start shows whether successive requests join into one seamless sequence.
- A stalled consumer, with a second request waiting, shows whether the held result stays fixed and whether a drain and a fill in the same cycle keep the second result.

// File: rtl/vidx_pkg.sv
package vidx_pkg;
  typedef enum logic [1:0] {
    ESZ_8   = 2'd0,
    ESZ_16  = 2'd1,
    ESZ_32  = 2'd2,
    ESZ_RSV = 2'd3
  } esize_e;

  // Reserved size code falls back to the widest element.
  function automatic logic [1:0] esize_eff(input logic [1:0] code);
    return (code == ESZ_RSV) ? 2'(ESZ_32) : code;
  endfunction
endpackage

// File: rtl/vidx_lane_gen.sv
module vidx_lane_gen #(
  parameter int VEC_W    = 128,
  parameter int ELEM_W   = 8,
  parameter int SCALAR_W = 32
) (
  input  logic [SCALAR_W-1:0] start,
  input  logic [1:0]          step_code,
  input  logic                dec,
  output logic [VEC_W-1:0]    vec
);
  localparam int LANES = VEC_W / ELEM_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SCALAR_W-1:0] offset;
    logic [SCALAR_W-1:0] sum;
    assign offset = SCALAR_W'(i) << step_code;
    assign sum    = dec ? (start - offset) : (start + offset);
    assign vec[i*ELEM_W +: ELEM_W] = sum[ELEM_W-1:0];
  end
endmodule

// File: rtl/vidx_next_calc.sv
module vidx_next_calc
  import vidx_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic [SCALAR_W-1:0] start,
  input  logic [1:0]          step_code,
  input  logic                dec,
  input  logic [1:0]          esize,
  output logic [SCALAR_W-1:0] next
);
  localparam int VEC_LOG2  = $clog2(VEC_W);
  localparam int MIN_ELOG2 = 3;

  logic [3:0]          lanes_log2;
  logic [4:0]          shamt;
  logic [SCALAR_W-1:0] advance;

  always_comb begin
    lanes_log2 = 4'(VEC_LOG2 - MIN_ELOG2) - {2'b00, esize_eff(esize)};
    shamt      = {1'b0, lanes_log2} + {3'b000, step_code};
    advance    = SCALAR_W'(1) << shamt;
    next       = dec ? (start - advance) : (start + advance);
  end
endmodule

// File: rtl/vidx_out_stage.sv
module vidx_out_stage #(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [VEC_W-1:0]    vec_d,
  input  logic [SCALAR_W-1:0] next_d,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [VEC_W-1:0]    out_vec,
  output logic [SCALAR_W-1:0] out_next,
  output logic                can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_next  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_vec   <= vec_d;
      out_next  <= next_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Stalled result must not move.
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_next)));

  // A loaded request always shows up as valid in the next cycle.
  assert_valid_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
endmodule

// File: rtl/vidx_seq_gen.sv
module vidx_seq_gen
  import vidx_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int SCALAR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SCALAR_W-1:0] in_start,
  input  logic [1:0]          in_step,
  input  logic                in_dec,
  input  logic [1:0]          in_esize,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VEC_W-1:0]    out_vec,
  output logic [SCALAR_W-1:0] out_next
);
  localparam int NUM_SIZES = 3;

  logic [VEC_W-1:0]    size_vec [NUM_SIZES];
  logic [VEC_W-1:0]    vec_sel;
  logic [SCALAR_W-1:0] next_val;
  logic                accept;
  logic [SCALAR_W-1:0] step_amt;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    vidx_lane_gen #(
      .VEC_W   (VEC_W),
      .ELEM_W  (8 << g),
      .SCALAR_W(SCALAR_W)
    ) u_lanes (
      .start    (in_start),
      .step_code(in_step),
      .dec      (in_dec),
      .vec      (size_vec[g])
    );
  end

  always_comb begin
    case (esize_eff(in_esize))
      ESZ_8:   vec_sel = size_vec[0];
      ESZ_16:  vec_sel = size_vec[1];
      default: vec_sel = size_vec[2];
    endcase
  end

  vidx_next_calc #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_next (
    .start    (in_start),
    .step_code(in_step),
    .dec      (in_dec),
    .esize    (in_esize),
    .next     (next_val)
  );

  assign accept = in_valid && in_ready;

  vidx_out_stage #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .vec_d    (vec_sel),
    .next_d   (next_val),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_vec  (out_vec),
    .out_next (out_next),
    .can_load (in_ready)
  );

  assign step_amt = SCALAR_W'(1) << in_step;

  // Lane 0 carries the start value.
  assert_lane0_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_vec[7:0] == $past(in_start[7:0])));

  // 8-bit lanes: spacing of lanes 0 and 1 follows step and direction.
  assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_esize == 2'd0) |=>
      ((out_vec[15:8] - out_vec[7:0]) ==
       ($past(in_dec) ? (8'd0 - $past(step_amt[7:0])) : $past(step_amt[7:0]))));

  // 32-bit lanes: continuation scalar sits one step beyond the top lane.
  assert_next_past_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_esize == 2'd2) |=>
      (out_vec[VEC_W-1 -: 32] == 32'($past(in_dec) ? (out_next + $past(step_amt))
                                                   : (out_next - $past(step_amt)))));
endmodule

// File: tb/sim_vidx_seq_gen.sv
module sim_vidx_seq_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_start = '0;
  logic [1:0]   in_step = '0;
  logic         in_dec = 1'b0;
  logic [1:0]   in_esize = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;
  logic [31:0]  out_next;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vidx_seq_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_step(in_step), .in_dec(in_dec), .in_esize(in_esize),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec), .out_next(out_next)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ew_of(input logic [1:0] ez);
    return (ez == 2'd0) ? 8 : (ez == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [127:0] exp_vec(input logic [31:0] s, input logic [1:0] sc,
                                           input logic d, input logic [1:0] ez);
    logic [127:0] r;
    int ew;
    int n;
    logic [31:0] v;
    r  = '0;
    ew = ew_of(ez);
    n  = 128 / ew;
    for (int i = 0; i < n; i++) begin
      v = d ? s - 32'(i * (1 << sc)) : s + 32'(i * (1 << sc));
      for (int b = 0; b < ew; b++) r[i*ew + b] = v[b];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] s, input logic [1:0] sc,
                                           input logic d, input logic [1:0] ez);
    logic [31:0] adv;
    adv = 32'((128 / ew_of(ez)) * (1 << sc));
    return d ? s - adv : s + adv;
  endfunction

  // One request through an idle, non-stalled output; checks vector and scalar.
  task automatic run_one(input logic [31:0] s, input logic [1:0] sc, input logic d,
                         input logic [1:0] ez, input string tag);
    logic [127:0] ev;
    logic [31:0]  en;
    ev = exp_vec(s, sc, d, ez);
    en = exp_next(s, sc, d, ez);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_start = s; in_step = sc; in_dec = d; in_esize = ez;
    chk(in_ready == 1'b1, {tag, " R8 in_ready"}, 128'(in_ready), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " R8 out_valid"}, 128'(out_valid), 128'(1));
    chk(out_vec == ev, {tag, " vec"}, out_vec, ev);
    chk(out_next == en, {tag, " R6 next"}, 128'(out_next), 128'(en));
  endtask

  task automatic t_reset;
    #1;
    chk(out_valid == 1'b0, "R10 out_valid", 128'(out_valid), 128'(0));
    chk(out_vec == '0, "R10 out_vec", out_vec, 128'(0));
    chk(out_next == '0, "R10 out_next", 128'(out_next), 128'(0));
    chk(in_ready == 1'b1, "R10 in_ready", 128'(in_ready), 128'(1));
  endtask

  task automatic t_example_dec16;
    logic [127:0] ev;
    ev = {16'd6, 16'd8, 16'd10, 16'd12, 16'd14, 16'd16, 16'd18, 16'd20};
    run_one(32'd20, 2'd1, 1'b1, 2'd1, "R3 R5 dec16");
    chk(out_vec == ev, "R3 literal lanes 20..6", out_vec, ev);
    chk(out_next == 32'd4, "R6 literal next", 128'(out_next), 128'(4));
    chk(out_vec[15:0] == 16'd20, "R1 lane0", 128'(out_vec[15:0]), 128'(20));
  endtask

  task automatic t_wrap8;
    // up from 0xFE step 1: lanes FE FF 00 01 ...
    run_one(32'h0000_00FE, 2'd0, 1'b0, 2'd0, "R7 R2 inc8 wrap");
    chk(out_vec[23:16] == 8'h00, "R7 lane2 wraps", 128'(out_vec[23:16]), 128'(0));
    // down from 3 step 4: lanes 03 FF FB ...
    run_one(32'd3, 2'd2, 1'b1, 2'd0, "R7 R3 dec8 below zero");
    chk(out_vec[15:8] == 8'hFF, "R7 lane1 below zero", 128'(out_vec[15:8]), 128'hFF);
  endtask

  task automatic t_steps;
    for (int k = 0; k < 4; k++)
      run_one(32'h1000, 2'(k), 1'b0, 2'd2, "R4 step code");
    run_one(32'hFFFF_FFF0, 2'd3, 1'b0, 2'd2, "R7 R6 inc32 wrap");
    run_one(32'h1234_5678, 2'd2, 1'b1, 2'd3, "R5 reserved size");
  endtask

  task automatic t_chain;
    logic [31:0] nx;
    run_one(32'd100, 2'd1, 1'b0, 2'd1, "R6 chain first");
    nx = out_next;
    chk(nx == 32'd116, "R6 chain next", 128'(nx), 128'(116));
    run_one(nx, 2'd1, 1'b0, 2'd1, "R6 chain second");
    chk(out_vec[15:0] == 16'd116, "R1 chain lane0", 128'(out_vec[15:0]), 128'(116));
  endtask

  task automatic t_backpressure;
    logic [127:0] ea, eb;
    ea = exp_vec(32'd40, 2'd0, 1'b0, 2'd0);
    eb = exp_vec(32'd900, 2'd3, 1'b1, 2'd1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_start = 32'd40; in_step = 2'd0; in_dec = 1'b0; in_esize = 2'd0;
    @(negedge clk);
    in_start = 32'd900; in_step = 2'd3; in_dec = 1'b1; in_esize = 2'd1;
    chk(in_ready == 1'b0, "R9 in_ready low when stalled", 128'(in_ready), 128'(0));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid held", 128'(out_valid), 128'(1));
    chk(out_vec == ea, "R9 vec held, pending ignored", out_vec, ea);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 refill on drain", 128'(out_valid), 128'(1));
    chk(out_vec == eb, "R8 second result", out_vec, eb);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 empties after drain", 128'(out_valid), 128'(0));
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_example_dec16();
    t_wrap8();
    t_steps();
    t_chain();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule